// File: doc/BRIEF.md
# Descriptor-Chained Block Copy Channel

This block is a single copy channel that moves 32-bit words from a source region to a destination region over one shared word-wide memory port. Each item is read from the source and then written to the destination, with both addresses advancing by four bytes per item. Software-style control is a start pulse with the job parameters on the inputs and a stop pulse that ends a running job early.

Four job kinds are selected by a 2-bit mode input. A single job copies one block. A contiguous job copies a fixed number of equal blocks back to back. A chained job walks a list of five-word descriptors in memory, one block per descriptor. A looping chained job does the same but never ends by itself. The channel counts blocks per buffer, pulses at each block and at each buffer boundary, and on completion or stop reports how many items it moved.

Top module: `lldma_channel`

## Requirements
- R1: A single job (mode 0) copies `block_items` words from `src_addr` upward to `dst_addr` upward. It then pulses `done` for one cycle, drops `busy` in that same cycle and leaves `moved` equal to `block_items`.
- R2: A start is rejected when the 16-bit item count is 0 or above 4095 in modes 0 and 1, or when `buffer_blocks` is 0 in modes 1 to 3. A rejected start sets `error`, makes no memory access and raises no `done`. The next accepted start clears `error`. A count of exactly 4095 is accepted.
- R3: A contiguous job (mode 1) copies `buffer_blocks` blocks of `block_items` words each. The blocks sit back to back in both regions, and `chain_head` is ignored. `done` rises after the last block.
- R4: In modes 2 and 3 each descriptor is five words read at pointer+0, +4, +8, +12 and +16, in that order, before any data read of its block. The words are: source address, destination address, next pointer, a control word whose bits [2:0] hold the burst code, and a control word whose bits [15:0] hold the item count. A descriptor with an invalid count sets `error` and stops the job without `done`.
- R5: In a chained job (mode 2), a next pointer of zero ends the walk. `done` follows that block.
- R6: In a looping job (mode 3), the next pointer is always followed, so a list whose last entry points at the head is revisited until a stop.
- R7: The channel never writes to descriptor memory. Every write lands in a block's destination range.
- R8: `block_done` pulses for one cycle after the last write of each block. `buffer_done` pulses with it when the per-buffer block count reaches `buffer_blocks`, and the count then restarts from zero. A single job counts as one buffer of one block.
- R9: Burst codes 0 to 7 group 1, 4, 8, 16, 32, 64, 128 and 256 items. A stop takes effect only at the end of a burst or block, so a stopped job's `moved` is a multiple of the burst size within its block.
- R10: A stop pulse during a job ends it with a `done` pulse, and `moved` equals the number of writes made. A stop pulse while idle has no effect on the next job.
- R11: A start pulse while `busy` is ignored, and the running job finishes unchanged.
- R12: After reset `busy`, `mem_req`, `done` and `error` are low. A request holds its address and direction until `mem_ack`, and only one access is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job with the parameters below (one cycle) |
| stop | input | 1 | End the running job at the next burst boundary |
| mode | input | 2 | 0 single, 1 contiguous, 2 chained, 3 looping chained |
| src_addr | input | 32 | First source byte address (modes 0, 1) |
| dst_addr | input | 32 | First destination byte address (modes 0, 1) |
| chain_head | input | 32 | First descriptor byte address (modes 2, 3) |
| block_items | input | 16 | Items per block (modes 0, 1) |
| buffer_blocks | input | CNT_W | Blocks per buffer |
| burst_code | input | 3 | Burst grouping code (modes 0, 1) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access accepted this cycle; read data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | A job is running |
| block_done | output | 1 | One-cycle pulse per finished block |
| buffer_done | output | 1 | One-cycle pulse per finished buffer |
| done | output | 1 | One-cycle pulse when a job ends normally or by stop |
| error | output | 1 | Last start or descriptor was invalid |
| moved | output | LEN_W | Items written in the current or last job |

## Verification
Single and contiguous jobs are run with random lengths, offsets and burst codes while the memory acknowledges randomly. This separates a correct address walk and item count from off-by-one and stall-handling faults. Chains with scattered descriptors, with one and with several blocks per buffer, check the fetch order, the end-of-list rule, the buffer counter reload and that descriptor words stay untouched. Stops issued against small, large and looping jobs, plus the count boundaries 0, 4095 and 4096, tell burst-aligned termination and length reporting apart from rejection.

// File: rtl/lldma_pkg.sv
package lldma_pkg;

    localparam int DESC_WORDS = 5;
    localparam int SIZE_W     = 16;
    localparam int MAX_ITEMS  = 4095;
    localparam int BURST_W    = 9;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_CONTIG = 2'd1,
        MODE_CHAIN  = 2'd2,
        MODE_RING   = 2'd3
    } xfer_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_READ,
        ST_WRITE
    } chan_state_e;

    typedef struct packed {
        logic [31:0]       src;
        logic [31:0]       dst;
        logic [31:0]       next;
        logic [2:0]        burst;
        logic [SIZE_W-1:0] items;
    } desc_t;

    // Items grouped per burst: 1, then 4 doubling up to 256.
    function automatic logic [BURST_W-1:0] burst_items(input logic [2:0] code);
        if (code == 3'd0) return BURST_W'(1);
        return BURST_W'(1) << ({1'b0, code} + 4'd1);
    endfunction

    function automatic logic size_ok(input logic [SIZE_W-1:0] n);
        return (n != '0) && (n <= SIZE_W'(MAX_ITEMS));
    endfunction

endpackage

// File: rtl/lldma_desc_loader.sv
module lldma_desc_loader
    import lldma_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        begin_i,
    input  logic [31:0] ptr_i,
    input  logic        step_i,
    input  logic [31:0] word_i,
    output logic [31:0] addr_o,
    output logic        last_o,
    output desc_t       desc_o
);
    localparam int IDX_W = $clog2(DESC_WORDS);

    logic [31:0]      base_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            idx_q  <= '0;
            desc_o <= '0;
        end else if (begin_i) begin
            base_q <= ptr_i;
            idx_q  <= '0;
        end else if (step_i) begin
            idx_q <= idx_q + IDX_W'(1);
            case (idx_q)
                IDX_W'(0): desc_o.src   <= word_i;
                IDX_W'(1): desc_o.dst   <= word_i;
                IDX_W'(2): desc_o.next  <= word_i;
                IDX_W'(3): desc_o.burst <= word_i[2:0];
                IDX_W'(4): desc_o.items <= word_i[SIZE_W-1:0];
                default: ;
            endcase
        end
    end

    assign addr_o = base_q + (32'(idx_q) << 2);
    assign last_o = (idx_q == IDX_W'(DESC_WORDS - 1));

endmodule

// File: rtl/lldma_beat_ctr.sv
module lldma_beat_ctr
    import lldma_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load_i,
    input  logic               rearm_i,
    input  logic [SIZE_W-1:0]  size_i,
    input  logic [BURST_W-1:0] burst_i,
    input  logic               step_i,
    output logic               block_end_o,
    output logic               burst_end_o
);
    logic [SIZE_W-1:0]  size_q;
    logic [SIZE_W-1:0]  left_q;
    logic [BURST_W-1:0] burst_q;
    logic [BURST_W-1:0] beat_q;

    assign block_end_o = (left_q == SIZE_W'(1));
    assign burst_end_o = block_end_o || ((beat_q + BURST_W'(1)) == burst_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            size_q  <= '0;
            left_q  <= '0;
            burst_q <= BURST_W'(1);
            beat_q  <= '0;
        end else if (load_i) begin
            size_q  <= size_i;
            left_q  <= size_i;
            burst_q <= burst_i;
            beat_q  <= '0;
        end else if (rearm_i) begin
            left_q <= size_q;
            beat_q <= '0;
        end else if (step_i) begin
            left_q <= left_q - SIZE_W'(1);
            beat_q <= burst_end_o ? '0 : beat_q + BURST_W'(1);
        end
    end

endmodule

// File: rtl/lldma_blk_ctr.sv
module lldma_blk_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] target_i,
    input  logic             step_i,
    output logic             hit_o
);
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] target_q;

    assign hit_o = ((count_q + CNT_W'(1)) == target_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            target_q <= '0;
        end else if (load_i) begin
            count_q  <= '0;
            target_q <= target_i;
        end else if (step_i) begin
            count_q <= hit_o ? '0 : count_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/lldma_channel.sv
module lldma_channel
    import lldma_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LEN_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic [1:0]        mode,
    input  logic [31:0]       src_addr,
    input  logic [31:0]       dst_addr,
    input  logic [31:0]       chain_head,
    input  logic [15:0]       block_items,
    input  logic [CNT_W-1:0]  buffer_blocks,
    input  logic [2:0]        burst_code,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              busy,
    output logic              block_done,
    output logic              buffer_done,
    output logic              done,
    output logic              error,
    output logic [LEN_W-1:0]  moved
);
    chan_state_e state_q, state_d;
    xfer_mode_e  mode_q;
    xfer_mode_e  mode_in;
    logic [31:0] src_q, dst_q, next_q, data_q;
    logic        term_q;

    desc_t       desc;
    logic [31:0] fetch_addr;
    logic        fetch_last;
    logic        block_end, burst_end, buf_hit;

    logic               ld_begin;
    logic [31:0]        ld_ptr;
    logic               bt_load, bt_rearm;
    logic [SIZE_W-1:0]  bt_size;
    logic [BURST_W-1:0] bt_burst;
    logic               bc_load;
    logic [CNT_W-1:0]   bc_target;

    logic accept, reject, fe_fire, rd_fire, wr_fire, desc_bad, finish;

    assign mode_in = xfer_mode_e'(mode);
    assign fe_fire = (state_q == ST_FETCH) && mem_ack;
    assign rd_fire = (state_q == ST_READ)  && mem_ack;
    assign wr_fire = (state_q == ST_WRITE) && mem_ack;

    assign reject  = ((mode_in != MODE_SINGLE) && (buffer_blocks == '0)) ||
                     (!mode[1] && !size_ok(block_items));
    assign accept  = (state_q == ST_IDLE) && start && !reject;
    assign desc_bad = (state_q == ST_CHECK) && !term_q && !size_ok(desc.items);

    // Sequencing of the job and the strobes to the counters.
    always_comb begin
        state_d   = state_q;
        finish    = 1'b0;
        ld_begin  = 1'b0;
        ld_ptr    = chain_head;
        bt_load   = 1'b0;
        bt_rearm  = 1'b0;
        bt_size   = block_items;
        bt_burst  = burst_items(burst_code);
        bc_load   = accept;
        bc_target = (mode_in == MODE_SINGLE) ? CNT_W'(1) : buffer_blocks;
        case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (mode[1]) begin
                        ld_begin = 1'b1;
                        state_d  = ST_FETCH;
                    end else begin
                        bt_load = 1'b1;
                        state_d = ST_READ;
                    end
                end
            end
            ST_FETCH: begin
                if (fe_fire && fetch_last) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                if (term_q) begin
                    finish  = 1'b1;
                    state_d = ST_IDLE;
                end else if (desc_bad) begin
                    state_d = ST_IDLE;
                end else begin
                    bt_load  = 1'b1;
                    bt_size  = desc.items;
                    bt_burst = burst_items(desc.burst);
                    state_d  = ST_READ;
                end
            end
            ST_READ: begin
                if (rd_fire) state_d = ST_WRITE;
            end
            ST_WRITE: begin
                if (wr_fire) begin
                    if (block_end) begin
                        case (mode_q)
                            MODE_SINGLE: finish = 1'b1;
                            MODE_CONTIG: begin
                                if (buf_hit || term_q) finish = 1'b1;
                                else bt_rearm = 1'b1;
                            end
                            MODE_CHAIN: begin
                                if (term_q || (next_q == '0)) finish = 1'b1;
                                else ld_begin = 1'b1;
                            end
                            default: begin
                                if (term_q) finish = 1'b1;
                                else ld_begin = 1'b1;
                            end
                        endcase
                        ld_ptr = next_q;
                        if (finish)        state_d = ST_IDLE;
                        else if (ld_begin) state_d = ST_FETCH;
                        else               state_d = ST_READ;
                    end else if (burst_end && term_q) begin
                        finish  = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_READ;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            mode_q      <= MODE_SINGLE;
            src_q       <= '0;
            dst_q       <= '0;
            next_q      <= '0;
            data_q      <= '0;
            term_q      <= 1'b0;
            done        <= 1'b0;
            block_done  <= 1'b0;
            buffer_done <= 1'b0;
            error       <= 1'b0;
            moved       <= '0;
        end else begin
            state_q     <= state_d;
            done        <= finish;
            block_done  <= wr_fire && block_end;
            buffer_done <= wr_fire && block_end && buf_hit;

            if (state_q == ST_IDLE && start) error <= reject;
            else if (desc_bad)               error <= 1'b1;

            if (accept) begin
                mode_q <= mode_in;
                src_q  <= src_addr;
                dst_q  <= dst_addr;
                term_q <= 1'b0;
                moved  <= '0;
            end else begin
                if (state_q != ST_IDLE && stop) term_q <= 1'b1;
                if (finish) term_q <= 1'b0;
                if (state_q == ST_CHECK) begin
                    src_q  <= desc.src;
                    dst_q  <= desc.dst;
                    next_q <= desc.next;
                end
                if (rd_fire) data_q <= mem_rdata;
                if (wr_fire) begin
                    src_q <= src_q + 32'd4;
                    dst_q <= dst_q + 32'd4;
                    moved <= moved + LEN_W'(1);
                end
            end
        end
    end

    lldma_desc_loader u_loader (
        .clk     (clk),
        .rst     (rst),
        .begin_i (ld_begin),
        .ptr_i   (ld_ptr),
        .step_i  (fe_fire),
        .word_i  (mem_rdata),
        .addr_o  (fetch_addr),
        .last_o  (fetch_last),
        .desc_o  (desc)
    );

    lldma_beat_ctr u_beats (
        .clk         (clk),
        .rst         (rst),
        .load_i      (bt_load),
        .rearm_i     (bt_rearm),
        .size_i      (bt_size),
        .burst_i     (bt_burst),
        .step_i      (wr_fire),
        .block_end_o (block_end),
        .burst_end_o (burst_end)
    );

    lldma_blk_ctr #(.CNT_W(CNT_W)) u_blocks (
        .clk      (clk),
        .rst      (rst),
        .load_i   (bc_load),
        .target_i (bc_target),
        .step_i   (wr_fire && block_end),
        .hit_o    (buf_hit)
    );

    assign busy      = (state_q != ST_IDLE);
    assign mem_req   = (state_q == ST_FETCH) || (state_q == ST_READ) || (state_q == ST_WRITE);
    assign mem_we    = (state_q == ST_WRITE);
    assign mem_addr  = (state_q == ST_FETCH) ? fetch_addr :
                       (state_q == ST_WRITE) ? dst_q : src_q;
    assign mem_wdata = data_q;

endmodule

// File: rtl/lldma_channel_chk.sv
module lldma_channel_chk #(
    parameter int LEN_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             done,
    input logic             error,
    input logic             block_done,
    input logic             buffer_done,
    input logic             mem_req,
    input logic             mem_we,
    input logic             mem_ack,
    input logic [31:0]      mem_addr,
    input logic [LEN_W-1:0] moved
);
    // R12: no access while idle
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

    // R12: a pending request is held unchanged
    assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R1: completion coincides with leaving the busy state
    assert_done_ends_R1: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && $past(busy));

    // R8: a buffer boundary is always a block boundary
    assert_buf_on_blk_R8: assert property (@(posedge clk) disable iff (rst)
        buffer_done |-> block_done);

    // R8: a block ends only right after an accepted write
    assert_blk_after_write_R8: assert property (@(posedge clk) disable iff (rst)
        block_done |-> $past(mem_req && mem_we && mem_ack));

    // R10: the moved count advances only by one accepted write
    assert_len_step_R10: assert property (@(posedge clk) disable iff (rst)
        $past(busy) && (moved != $past(moved)) |->
            (moved == $past(moved) + 1'b1) && $past(mem_req && mem_we && mem_ack));

    // R2: a rejection never reports completion
    assert_err_no_done_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(error) |-> !done);
endmodule

bind lldma_channel lldma_channel_chk #(.LEN_W(LEN_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .done        (done),
    .error       (error),
    .block_done  (block_done),
    .buffer_done (buffer_done),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_ack     (mem_ack),
    .mem_addr    (mem_addr),
    .moved       (moved)
);

// File: tb/lldma_channel_tb_top.sv
`timescale 1ns/1ps
module lldma_channel_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        start, stop;
    logic [1:0]  mode;
    logic [31:0] src_addr, dst_addr, chain_head;
    logic [15:0] block_items;
    logic [15:0] buffer_blocks;
    logic [2:0]  burst_code;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        busy, block_done, buffer_done, done, error;
    logic [31:0] moved;

    always #2 clk = ~clk;

    lldma_channel dut_i (
        .clk(clk), .rst(rst), .start(start), .stop(stop), .mode(mode),
        .src_addr(src_addr), .dst_addr(dst_addr), .chain_head(chain_head),
        .block_items(block_items), .buffer_blocks(buffer_blocks),
        .burst_code(burst_code), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .busy(busy), .block_done(block_done),
        .buffer_done(buffer_done), .done(done), .error(error), .moved(moved)
    );

    logic [31:0] mem [0:8191];
    assign mem_rdata = mem[mem_addr[14:2]];

    int total = 0, bad = 0;
    int blk_cnt = 0, buf_cnt = 0, done_cnt = 0, wr_cnt = 0, acc_cnt = 0, rd_cnt = 0, stray = 0;
    logic [31:0] rd_log [0:63];
    int s_blk, s_buf, s_done, s_wr, s_acc, s_rd;

    // Memory model and event monitor, all at the falling edge.
    always @(negedge clk) begin
        if (rst) begin
            mem_ack = 1'b0;
        end else begin
            mem_ack = (($urandom % 4) != 0);
            if (block_done)  blk_cnt++;
            if (buffer_done) buf_cnt++;
            if (done)        done_cnt++;
            if (mem_req && mem_ack) begin
                acc_cnt++;
                if (mem_we) begin
                    mem[mem_addr[14:2]] = mem_wdata;
                    wr_cnt++;
                    if (mem_addr < 32'h4000 || mem_addr >= 32'h7000) stray++;
                end else begin
                    rd_log[rd_cnt % 64] = mem_addr;
                    rd_cnt++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_burst(input int code);
        return (code == 0) ? 1 : (1 << (code + 1));
    endfunction

    task automatic clr_dst();
        for (int i = 4096; i < 7168; i++) mem[i] = 32'h0;
    endtask

    function automatic int copy_errs(input int sw, input int dw, input int n);
        int e = 0;
        for (int i = 0; i < n; i++) if (mem[dw + i] !== mem[sw + i]) e++;
        return e;
    endfunction

    task automatic put_desc(input int at, input int s, input int d, input int nx,
                            input int bc, input int n);
        mem[at / 4]     = s;
        mem[at / 4 + 1] = d;
        mem[at / 4 + 2] = nx;
        mem[at / 4 + 3] = 32'hABCD_0000 | bc;
        mem[at / 4 + 4] = 32'h5A00_0000 | n;
    endtask

    task automatic launch(input int md, input int s, input int d, input int head,
                          input int n, input int cnt, input int bc);
        @(negedge clk);
        mode = md[1:0]; src_addr = s; dst_addr = d; chain_head = head;
        block_items = n[15:0]; buffer_blocks = cnt[15:0]; burst_code = bc[2:0];
        s_blk = blk_cnt; s_buf = buf_cnt; s_done = done_cnt;
        s_wr = wr_cnt; s_acc = acc_cnt; s_rd = rd_cnt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end(input string req);
        int n = 0;
        bit ok = 0;
        while (n < 40000) begin
            if (done_cnt != s_done || error) begin ok = 1; break; end
            @(negedge clk);
            n++;
        end
        repeat (2) @(negedge clk);
        chk(ok, req, "job end timeout", n, 0);
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n, sw, dw, bc, cnt_a;
        logic [31:0] dcopy [0:14];
        void'($urandom(32'd7151));
        rst = 1'b1; start = 0; stop = 0; mode = 0; src_addr = 0; dst_addr = 0;
        chain_head = 0; block_items = 0; buffer_blocks = 0; burst_code = 0;
        for (int i = 0; i < 8192; i++) mem[i] = 32'h0;
        for (int i = 0; i < 2048; i++) mem[i] = $urandom | 32'h1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12: reset state
        chk(!busy && !mem_req && !done && !error, "R12", "reset outputs",
            {busy, mem_req, done, error}, 0);

        // R1, R8: directed single block
        clr_dst();
        launch(0, 40 * 4, 32'h4000, 0, 7, 5, 0);
        wait_end("R1");
        chk(moved == 7, "R1", "single moved", moved, 7);
        chk(copy_errs(40, 4096, 7) == 0, "R1", "single data errors", copy_errs(40, 4096, 7), 0);
        chk(blk_cnt - s_blk == 1 && buf_cnt - s_buf == 1, "R8", "single block/buffer pulses",
            (blk_cnt - s_blk) * 10 + (buf_cnt - s_buf), 11);
        chk(mem[4096 + 7] == 0, "R1", "no write past block", mem[4096 + 7], 0);

        // R1, R9: random single jobs with random burst codes
        for (int k = 0; k < 4; k++) begin
            clr_dst();
            n  = 1 + $urandom % 40;
            sw = $urandom % 1000;
            dw = 4096 + $urandom % 1000;
            bc = $urandom % 8;
            launch(0, sw * 4, dw * 4, 0, n, 1, bc);
            wait_end("R1");
            chk(moved == n && done_cnt - s_done == 1, "R1", "random single moved", moved, n);
            chk(copy_errs(sw, dw, n) == 0, "R9", "random single data (any burst)", copy_errs(sw, dw, n), 0);
        end

        // R2: rejected counts
        launch(0, 0, 32'h4000, 0, 0, 1, 0);
        repeat (20) @(negedge clk);
        chk(error && acc_cnt == s_acc && done_cnt == s_done, "R2", "count 0 rejected",
            {error, 8'(acc_cnt - s_acc)}, 256);
        launch(1, 0, 32'h4000, 0, 4096, 2, 0);
        repeat (20) @(negedge clk);
        chk(error && acc_cnt == s_acc && !busy, "R2", "count 4096 rejected", acc_cnt - s_acc, 0);
        launch(1, 0, 32'h4000, 0, 4, 0, 0);
        repeat (20) @(negedge clk);
        chk(error && acc_cnt == s_acc, "R2", "block count 0 rejected", acc_cnt - s_acc, 0);

        // R2, R10: 4095 accepted, stopped early
        launch(0, 0, 32'h4000, 0, 4095, 1, 0);
        chk(!error && busy, "R2", "count 4095 accepted", error, 0);
        repeat (10) @(negedge clk);
        pulse_stop();
        wait_end("R10");
        chk(!error && moved == wr_cnt - s_wr && moved > 0 && moved < 4095, "R10",
            "stop reports writes", moved, wr_cnt - s_wr);

        // R3, R8: contiguous multiblock, head ignored
        clr_dst();
        launch(1, 100 * 4, 32'h5000, 32'h7000, 5, 3, 1);
        wait_end("R3");
        chk(moved == 15, "R3", "contiguous moved", moved, 15);
        chk(copy_errs(100, 5120, 15) == 0, "R3", "contiguous data", copy_errs(100, 5120, 15), 0);
        chk(blk_cnt - s_blk == 3 && buf_cnt - s_buf == 1, "R8", "contiguous pulses",
            (blk_cnt - s_blk) * 10 + (buf_cnt - s_buf), 31);
        chk(rd_log[s_rd % 64] == 100 * 4, "R3", "first read at source not head",
            rd_log[s_rd % 64], 400);

        // R4, R5, R7, R8: three-entry chain
        clr_dst();
        put_desc(32'h7000, 10 * 4, 32'h4100, 32'h7200, 1, 4);
        put_desc(32'h7200, 300 * 4, 32'h4800, 32'h7400, 0, 6);
        put_desc(32'h7400, 600 * 4, 32'h6000, 0, 2, 3);
        for (int i = 0; i < 5; i++) begin
            dcopy[i] = mem[7168 + i]; dcopy[5 + i] = mem[7296 + i]; dcopy[10 + i] = mem[7424 + i];
        end
        launch(2, 0, 0, 32'h7000, 0, 3, 0);
        wait_end("R5");
        chk(moved == 13 && done_cnt - s_done == 1, "R5", "chain moved", moved, 13);
        chk(copy_errs(10, 4096 + 64, 4) + copy_errs(300, 4096 + 512, 6) + copy_errs(600, 6144, 3) == 0,
            "R5", "chain data", copy_errs(300, 4096 + 512, 6), 0);
        cnt_a = 0;
        for (int i = 0; i < 5; i++) if (rd_log[(s_rd + i) % 64] != 32'h7000 + 4 * i) cnt_a++;
        chk(cnt_a == 0, "R4", "descriptor read order", cnt_a, 0);
        cnt_a = 0;
        for (int i = 0; i < 5; i++) begin
            if (dcopy[i] != mem[7168 + i]) cnt_a++;
            if (dcopy[5 + i] != mem[7296 + i]) cnt_a++;
            if (dcopy[10 + i] != mem[7424 + i]) cnt_a++;
        end
        chk(cnt_a == 0 && stray == 0, "R7", "descriptors untouched", cnt_a + stray, 0);
        chk(blk_cnt - s_blk == 3 && buf_cnt - s_buf == 1, "R8", "chain pulses",
            (blk_cnt - s_blk) * 10 + (buf_cnt - s_buf), 31);

        // R8: buffer counter reloads (one block per buffer)
        put_desc(32'h7000, 10 * 4, 32'h4100, 32'h7200, 0, 2);
        put_desc(32'h7200, 20 * 4, 32'h4200, 0, 0, 2);
        launch(2, 0, 0, 32'h7000, 0, 1, 0);
        wait_end("R8");
        chk(buf_cnt - s_buf == 2 && done_cnt - s_done == 1, "R8", "buffer reload",
            buf_cnt - s_buf, 2);

        // R4: bad count inside a descriptor
        put_desc(32'h7000, 10 * 4, 32'h4100, 0, 0, 0);
        launch(2, 0, 0, 32'h7000, 0, 1, 0);
        wait_end("R4");
        chk(error && done_cnt == s_done && wr_cnt == s_wr, "R4", "bad descriptor count",
            wr_cnt - s_wr, 0);

        // R6, R10: looping list, stopped after five blocks
        put_desc(32'h7000, 50 * 4, 32'h4000, 32'h7100, 0, 3);
        put_desc(32'h7100, 70 * 4, 32'h5000, 32'h7000, 0, 2);
        launch(3, 0, 0, 32'h7000, 0, 2, 0);
        n = 0;
        while (blk_cnt - s_blk < 5 && n < 5000) begin @(negedge clk); n++; end
        pulse_stop();
        wait_end("R6");
        chk(done_cnt - s_done == 1 && !error, "R6", "ring ended by stop", done_cnt - s_done, 1);
        chk(buf_cnt - s_buf >= 2, "R6", "ring buffers", buf_cnt - s_buf, 2);
        cnt_a = 0;
        for (int i = s_rd; i < rd_cnt && i < s_rd + 64; i++) if (rd_log[i % 64] == 32'h7000) cnt_a++;
        chk(cnt_a >= 2, "R6", "head descriptor revisited", cnt_a, 2);
        chk(moved == wr_cnt - s_wr, "R10", "ring moved equals writes", moved, wr_cnt - s_wr);

        // R9: stop lands on a 4-item burst boundary
        clr_dst();
        launch(0, 200 * 4, 32'h4000, 0, 40, 1, 1);
        repeat (30) @(negedge clk);
        pulse_stop();
        wait_end("R9");
        chk(moved % exp_burst(1) == 0 && moved > 0 && moved < 40, "R9", "stop at 4-burst", moved, 4);
        chk(mem[4096 + moved] == 0 && moved == wr_cnt - s_wr, "R10", "no write after stop",
            mem[4096 + moved], 0);

        // R9: largest burst code
        launch(0, 0, 32'h4000, 0, 300, 1, 7);
        repeat (20) @(negedge clk);
        pulse_stop();
        wait_end("R9");
        chk(moved == exp_burst(7), "R9", "stop at 256-burst", moved, exp_burst(7));

        // R10: stop while idle has no effect
        pulse_stop();
        clr_dst();
        launch(0, 30 * 4, 32'h4400, 0, 9, 1, 0);
        wait_end("R10");
        chk(moved == 9, "R10", "idle stop ignored", moved, 9);

        // R11: start while busy ignored
        clr_dst();
        launch(0, 500 * 4, 32'h4000, 0, 20, 1, 0);
        repeat (10) @(negedge clk);
        start = 1'b1; src_addr = 32'h100; block_items = 3;
        @(negedge clk); start = 1'b0;
        wait_end("R11");
        chk(moved == 20 && done_cnt - s_done == 1, "R11", "busy start ignored", moved, 20);
        chk(copy_errs(500, 4096, 20) == 0, "R11", "first job data kept", copy_errs(500, 4096, 20), 0);

        repeat (5) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule